// File: doc/BRIEF.md
# Stack Processor Port Interface

This block connects a small 8-bit stack processor to the signals around it. The core issues a read command or a write command for one cycle and places the port address in its top-of-stack byte; for writes the data comes from the next-on-stack byte. A combinational multiplexer returns the byte of the addressed input port. Each input port can have a read strobe, and each output port a write strobe. Both strobes are registered and are high in the cycle after the access.

There are two kinds of input port. A data port returns the value of its external signals. A flag port captures a one-cycle event on its external line and keeps it, so the event is not lost between polls. The flag reads as all-ones while the line is high or the flag is held. A read of its address clears the flag. Output ports are registers of a set width, and each one resets to its own initial value. The number of ports, their addresses, their widths, the reset values and the reset polarity are all parameters.

Top module: `stack_io_ports`

## Requirements
- R1: Reset is synchronous. It is active high by default, and the parameter `RST_LOW=1` makes it active low. In reset, all strobes and flags clear and every output register takes its initial value (defaults: port 0x40 = 8'h06, port 0x41 = 8'hA5).
- R2: A read of an address with no port mapped to it returns 8'h00. An access to an unmapped address raises no strobe and changes no output register.
- R3: A data port returns its external value, zero-extended when the value is narrower than 8 bits and cut to its low 8 bits when it is wider. Default ports: address 0x00 is 4 bits wide, 0x01 is 8 bits wide and 0x05 is 12 bits wide. Each port takes the low bits of its 16-bit slot in `in_data`, with slot i at bits [16i+15:16i].
- R4: A read strobe bit is high for exactly the one cycle after a read command whose address matches that port, and low at all other times. Bit i belongs to data port i.
- R5: A flag port (defaults 0x20 for flag 0 and 0x21 for flag 1) reads as 8'hFF while its event line is high or its flag is held, and as 8'h00 otherwise.
- R6: A flag is set by a high event line and is cleared by a read command to its address. Clearing wins when both happen in the same cycle, so the event is lost. Otherwise the flag keeps its value.
- R7: On a write command to its address, an output register loads the low bits of `nos` up to its width, and the upper bits of its 8-bit slot read as zero. Otherwise the register holds its value. Defaults: 0x40 is 3 bits wide and 0x41 is 8 bits wide, with slot i at bits [8i+7:8i].
- R8: A write strobe bit is high for exactly the one cycle after a write command to that output port, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_in | input | 1 | Synchronous reset, polarity set by RST_LOW |
| rd_cmd | input | 1 | One-cycle read command |
| wr_cmd | input | 1 | One-cycle write command |
| tos | input | 8 | Port address (top of stack) |
| nos | input | 8 | Write data (next on stack) |
| in_data | input | N_IN*16 | External values of the data ports |
| sr_evt | input | N_SR | Event lines of the flag ports |
| rd_data | output | 8 | Byte returned for the addressed port |
| rd_stb | output | N_IN | Registered read strobes |
| wr_data | output | N_OUT*8 | Output registers |
| wr_stb | output | N_OUT | Registered write strobes |

## Verification
The collision that matters is an event on a flag line in the same cycle as a read that clears that flag. The bench drives the event and the read of address 0x20 together. During that cycle it expects 8'hFF on the read bus. Afterwards, with the line low, it expects 8'h00, which shows that the clear won. It then raises the event for one cycle with no read and expects the flag to read 8'hFF again. This shows that an event arriving one cycle later is kept.

// File: rtl/stack_io_ports.sv
module stack_io_ports #(
  parameter int N_IN = 3,
  parameter int IN_SLOT = 16,
  parameter logic [N_IN*8-1:0] IN_ADDR = {8'h05, 8'h01, 8'h00},
  parameter logic [N_IN*5-1:0] IN_WID = {5'd12, 5'd8, 5'd4},
  parameter int N_SR = 2,
  parameter logic [N_SR*8-1:0] SR_ADDR = {8'h21, 8'h20},
  parameter int N_OUT = 2,
  parameter logic [N_OUT*8-1:0] OUT_ADDR = {8'h41, 8'h40},
  parameter logic [N_OUT*4-1:0] OUT_WID = {4'd8, 4'd3},
  parameter logic [N_OUT*8-1:0] OUT_INIT = {8'hA5, 8'h06},
  parameter bit RST_LOW = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_in,
  input  logic                  rd_cmd,
  input  logic                  wr_cmd,
  input  logic [7:0]            tos,
  input  logic [7:0]            nos,
  input  logic [N_IN*IN_SLOT-1:0] in_data,
  input  logic [N_SR-1:0]       sr_evt,
  output logic [7:0]            rd_data,
  output logic [N_IN-1:0]       rd_stb,
  output logic [N_OUT*8-1:0]    wr_data,
  output logic [N_OUT-1:0]      wr_stb
);

  logic rst;
  assign rst = RST_LOW ? ~rst_in : rst_in;

  logic [N_IN-1:0]  in_hit;
  logic [7:0]       in_val [N_IN];
  logic [N_SR-1:0]  sr_hit, sr_q;
  logic [N_OUT-1:0] out_hit;
  logic             mapped;

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    localparam int W = int'(IN_WID[i*5 +: 5]);
    localparam logic [IN_SLOT-1:0] MASK =
      (W >= IN_SLOT) ? {IN_SLOT{1'b1}} : IN_SLOT'((64'd1 << W) - 64'd1);
    assign in_hit[i] = (tos == IN_ADDR[i*8 +: 8]);
    assign in_val[i] = 8'(in_data[i*IN_SLOT +: IN_SLOT] & MASK);

    always_ff @(posedge clk)
      if (rst) rd_stb[i] <= 1'b0;
      else     rd_stb[i] <= rd_cmd && in_hit[i];

    // R4
    rd_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> rd_stb[i] == $past(rd_cmd && tos == IN_ADDR[i*8 +: 8]));
  end

  for (genvar j = 0; j < N_SR; j++) begin : g_sr
    assign sr_hit[j] = (tos == SR_ADDR[j*8 +: 8]);

    always_ff @(posedge clk)
      if (rst)                     sr_q[j] <= 1'b0;
      else if (rd_cmd && sr_hit[j]) sr_q[j] <= 1'b0;
      else if (sr_evt[j])          sr_q[j] <= 1'b1;

    // R6
    flag_clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rd_cmd && sr_hit[j]) |-> !sr_q[j]);
    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && $past(sr_evt[j]) && !$past(rd_cmd && sr_hit[j]) |-> sr_q[j]);
    // R5
    flag_read_chk: assert property (@(posedge clk) disable iff (rst)
      sr_hit[j] && (sr_evt[j] || sr_q[j]) |-> rd_data == 8'hFF);
  end

  always_comb begin
    rd_data = 8'h00;
    mapped  = 1'b0;
    for (int i = 0; i < N_IN; i++)
      if (in_hit[i]) begin
        rd_data = in_val[i];
        mapped  = 1'b1;
      end
    for (int j = 0; j < N_SR; j++)
      if (sr_hit[j]) begin
        rd_data = (sr_evt[j] || sr_q[j]) ? 8'hFF : 8'h00;
        mapped  = 1'b1;
      end
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    localparam int W = int'(OUT_WID[k*4 +: 4]);
    localparam logic [7:0] MASK = (W >= 8) ? 8'hFF : 8'((16'd1 << W) - 16'd1);
    assign out_hit[k] = (tos == OUT_ADDR[k*8 +: 8]);

    always_ff @(posedge clk)
      if (rst)                       wr_data[k*8 +: 8] <= OUT_INIT[k*8 +: 8] & MASK;
      else if (wr_cmd && out_hit[k]) wr_data[k*8 +: 8] <= nos & MASK;

    always_ff @(posedge clk)
      if (rst) wr_stb[k] <= 1'b0;
      else     wr_stb[k] <= wr_cmd && out_hit[k];

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && !$past(wr_cmd && out_hit[k]) |-> $stable(wr_data[k*8 +: 8]));
    // R7
    out_load_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && $past(wr_cmd && out_hit[k]) |-> wr_data[k*8 +: 8] == ($past(nos) & MASK));
    // R8
    wr_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> wr_stb[k] == $past(wr_cmd && tos == OUT_ADDR[k*8 +: 8]));
  end

  // R2
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    !mapped |-> rd_data == 8'h00);
  // R2
  unmapped_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !mapped && !(|out_hit) |=> rd_stb == '0 && wr_stb == '0);

endmodule

// File: tb/tb_stack_io_ports.sv
module tb_stack_io_ports;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rstn_b = 1'b0;
  logic rd_cmd = 1'b0, wr_cmd = 1'b0;
  logic [7:0] tos = 8'hFF, nos = 8'h00;
  logic [47:0] in_data = '0;
  logic [1:0] sr_evt = '0;
  logic [7:0] rd_data, rd_data_b;
  logic [2:0] rd_stb, rd_stb_b;
  logic [15:0] wr_data, wr_data_b;
  logic [1:0] wr_stb, wr_stb_b;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  stack_io_ports dut (
    .clk(clk), .rst_in(rst), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .tos(tos), .nos(nos),
    .in_data(in_data), .sr_evt(sr_evt), .rd_data(rd_data), .rd_stb(rd_stb),
    .wr_data(wr_data), .wr_stb(wr_stb));

  stack_io_ports #(.RST_LOW(1'b1)) dut_n (
    .clk(clk), .rst_in(rstn_b), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .tos(tos), .nos(nos),
    .in_data(in_data), .sr_evt(sr_evt), .rd_data(rd_data_b), .rd_stb(rd_stb_b),
    .wr_data(wr_data_b), .wr_stb(wr_stb_b));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    tos = 8'hFF;
    #1;
    check("R1 rd_data", 16'(rd_data), 16'h0000);
    check("R1 rd_stb", 16'(rd_stb), 16'h0000);
    check("R1 wr_stb", 16'(wr_stb), 16'h0000);
    check("R1 wr_data init", wr_data, 16'hA506);
    check("R1 low-active init", wr_data_b, 16'hA506);
    tos = 8'h20;
    #1;
    check("R1 flag clear", 16'(rd_data), 16'h0000);
  endtask

  task automatic t_data_reads();
    in_data = {16'hFEDC, 16'h1234, 16'hABCD};
    tos = 8'h00; #1; check("R3 4-bit port", 16'(rd_data), 16'h000D);
    tos = 8'h01; #1; check("R3 8-bit port", 16'(rd_data), 16'h0034);
    tos = 8'h05; #1; check("R3 12-bit port", 16'(rd_data), 16'h00DC);
    in_data = {16'h0F00, 16'h00FF, 16'hFFF0};
    tos = 8'h00; #1; check("R3 4-bit zero", 16'(rd_data), 16'h0000);
    tos = 8'h05; #1; check("R3 12-bit cut", 16'(rd_data), 16'h0000);
    tos = 8'h01; #1; check("R3 8-bit full", 16'(rd_data), 16'h00FF);
  endtask

  task automatic t_unmapped();
    tos = 8'h07; #1;
    check("R2 unmapped read", 16'(rd_data), 16'h0000);
    rd_cmd = 1'b1; wr_cmd = 1'b1; nos = 8'h5A;
    step();
    rd_cmd = 1'b0; wr_cmd = 1'b0;
    check("R2 no rd strobe", 16'(rd_stb), 16'h0000);
    check("R2 no wr strobe", 16'(wr_stb), 16'h0000);
    check("R2 outputs unchanged", wr_data, 16'hA506);
  endtask

  task automatic t_rd_strobe();
    tos = 8'h01; rd_cmd = 1'b1;
    step();
    rd_cmd = 1'b0;
    check("R4 strobe high", 16'(rd_stb), 16'h0002);
    step();
    check("R4 strobe low", 16'(rd_stb), 16'h0000);
    tos = 8'h05; rd_cmd = 1'b1;
    step();
    rd_cmd = 1'b0;
    check("R4 strobe port 2", 16'(rd_stb), 16'h0004);
    step();
  endtask

  task automatic t_flags();
    tos = 8'h20; sr_evt = 2'b01;
    #1; check("R5 live event", 16'(rd_data), 16'h00FF);
    step();
    sr_evt = 2'b00;
    #1; check("R5 held flag", 16'(rd_data), 16'h00FF);
    tos = 8'h21; #1; check("R5 other flag clear", 16'(rd_data), 16'h0000);
    tos = 8'h20; rd_cmd = 1'b1;
    #1; check("R5 read while held", 16'(rd_data), 16'h00FF);
    step();
    rd_cmd = 1'b0;
    #1; check("R6 cleared by read", 16'(rd_data), 16'h0000);
    step();
    check("R6 holds clear", 16'(rd_data), 16'h0000);
    sr_evt = 2'b01; rd_cmd = 1'b1;
    #1; check("R5 collision cycle", 16'(rd_data), 16'h00FF);
    step();
    sr_evt = 2'b00; rd_cmd = 1'b0;
    #1; check("R6 event lost to clear", 16'(rd_data), 16'h0000);
    sr_evt = 2'b01;
    step();
    sr_evt = 2'b00;
    #1; check("R6 later event kept", 16'(rd_data), 16'h00FF);
    tos = 8'h21; sr_evt = 2'b10;
    step();
    sr_evt = 2'b00; tos = 8'h20; rd_cmd = 1'b1;
    step();
    rd_cmd = 1'b0; tos = 8'h21;
    #1; check("R6 other flag untouched", 16'(rd_data), 16'h00FF);
  endtask

  task automatic t_writes();
    tos = 8'h40; nos = 8'hFF; wr_cmd = 1'b1;
    step();
    wr_cmd = 1'b0; nos = 8'h00;
    check("R7 3-bit load", wr_data, 16'hA507);
    check("R8 strobe port 0", 16'(wr_stb), 16'h0001);
    step();
    check("R8 strobe low", 16'(wr_stb), 16'h0000);
    check("R7 holds", wr_data, 16'hA507);
    tos = 8'h41; nos = 8'h3C; wr_cmd = 1'b1;
    step();
    wr_cmd = 1'b0;
    check("R7 8-bit load", wr_data, 16'h3C07);
    check("R8 strobe port 1", 16'(wr_stb), 16'h0002);
    check("R7 low-active twin", wr_data_b, 16'h3C07);
    step();
  endtask

  task automatic t_low_reset();
    rstn_b = 1'b0;
    step();
    rstn_b = 1'b1;
    check("R1 low-active reset", wr_data_b, 16'hA506);
    check("R1 high reset idle", wr_data, 16'h3C07);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    step(); step(); step();
    rst = 1'b0; rstn_b = 1'b1;
    #1;
    t_reset();
    t_data_reads();
    t_unmapped();
    t_rd_strobe();
    t_flags();
    t_writes();
    t_low_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule